// File: doc/BRIEF.md
# SPI Slave Command Engine

This block is an SPI slave that lives entirely in a fast system clock domain. The SPI clock, data-in and select pins arrive asynchronously. They are resynchronised, and SCLK edges are found by comparing successive synchronised samples. The block runs in SPI mode 0: the slave takes the data-in line on each rising SCLK edge and changes MISO after each falling edge. All bytes travel most significant bit first.

Each selected transaction opens with a command byte. One command streams received bytes into an external receive buffer through a write port. Another streams an external transmit buffer out through a synchronous read port. The other two read or write one of sixteen 32-bit words in an external register bank. Buffer addresses start at zero in every transaction and step by one per byte. The next outgoing byte is fetched one SCLK half-period early, which hides the one-cycle read latency of the memory and of the register bank.

Top module: `spi_cmd_slave`

## Requirements
- R1: Bytes are shifted most significant bit first, both on data-in and on MISO.
- R2: The first byte after select goes low is the command. A command byte other than 0x01, 0x03, 0x8n or 0xCn makes the block ignore all further bytes, and MISO stays 0, until select goes high.
- R3: Command 0x03 writes every following byte into the receive buffer at addresses 0, 1, 2 and so on. Each write is a strobe one clock long, visible no later than four clock cycles after the rising SCLK edge that completes the byte.
- R4: Command 0x01 returns transmit-buffer bytes from address 0 upward, one per byte the master clocks. Data-in bytes during this command cause no writes of any kind.
- R5: Command 0x8n returns register n over the next four bytes, most significant byte first. Any bytes after those four read as 0x00.
- R6: Command 0xCn collects the next four bytes, most significant first, into one 32-bit value. It then gives a single write strobe to register n. Bytes after the fourth are ignored.
- R7: When select goes high, the bit count, the byte count, the addresses and the command state are all cleared. A partly shifted byte is discarded, and the next selection starts with a fresh command byte.
- R8: Buffer addresses wrap from the top address back to 0 when a stream runs past the end of a buffer.
- R9: MISO is 0 whenever select has been high for four clocks. Receive-side transfers work with SCLK as fast as one quarter of the system clock.
- R10: After reset, MISO and both write strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk_i | input | 1 | SPI clock pin, asynchronous |
| spi_mosi_i | input | 1 | SPI data from master, asynchronous |
| spi_ss_n_i | input | 1 | Active-low select, asynchronous |
| spi_miso_o | output | 1 | SPI data to master |
| rxb_we_o | output | 1 | Receive buffer write strobe |
| rxb_addr_o | output | ADDR_W | Receive buffer write address |
| rxb_wdata_o | output | 8 | Receive buffer write data |
| txb_addr_o | output | ADDR_W | Transmit buffer read address |
| txb_rdata_i | input | 8 | Transmit buffer read data, one-cycle latency |
| reg_idx_o | output | IDX_W | Register bank index |
| reg_rdata_i | input | REG_W | Register read data, one-cycle latency |
| reg_we_o | output | 1 | Register write strobe |
| reg_wdata_o | output | REG_W | Register write data |

## Verification
A pin edge reaches the edge detector after two synchroniser flops. The receive-buffer and register write strobes are then registered one clock later. The bench therefore requires every strobe to appear within 20 ns, or four 200 MHz clocks, of the rising SCLK edge that completes its byte, and it checks every strobe at the falling clock edge in which it appears. MISO settles at most three clocks after a falling SCLK edge. The bench master samples it at the next rising edge, four clocks later at the default rate. The register word is requested at the clock after the command byte is decoded and is loaded at the following falling edge.

// File: rtl/spi_cmd_pkg.sv
`timescale 1ns/1ps
package spi_cmd_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] OP_TX_STREAM = 8'h01;
  localparam logic [BYTE_W-1:0] OP_RX_STREAM = 8'h03;
  localparam logic [3:0]        OP_REG_RD_HI = 4'h8;
  localparam logic [3:0]        OP_REG_WR_HI = 4'hC;

  typedef enum logic [2:0] {
    MD_CMD, MD_RXSTR, MD_TXSTR, MD_REGRD, MD_REGWR, MD_SKIP
  } mode_e;

  function automatic mode_e decode_op(input logic [BYTE_W-1:0] op);
    if (op == OP_TX_STREAM)              return MD_TXSTR;
    else if (op == OP_RX_STREAM)         return MD_RXSTR;
    else if (op[7:4] == OP_REG_RD_HI)    return MD_REGRD;
    else if (op[7:4] == OP_REG_WR_HI)    return MD_REGWR;
    else                                 return MD_SKIP;
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
`timescale 1ns/1ps
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_i,
  input  logic mosi_i,
  input  logic ss_n_i,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic mosi_o,
  output logic active_o
);
  localparam int NPIN = 3;
  localparam logic [NPIN-1:0] IDLE_LVL = 3'b100;

  logic [NPIN-1:0] pin_raw;
  logic [NPIN-1:0] pin_s;
  logic            sclk_prev_q;

  assign pin_raw = {ss_n_i, mosi_i, sclk_i};

  generate
    for (genvar p = 0; p < NPIN; p++) begin : g_pin
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{IDLE_LVL[p]}};
        else     chain_q <= {chain_q[STAGES-2:0], pin_raw[p]};
      end
      assign pin_s[p] = chain_q[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) sclk_prev_q <= 1'b0;
    else     sclk_prev_q <= pin_s[0];
  end

  assign sclk_rise_o = pin_s[0] & ~sclk_prev_q;
  assign sclk_fall_o = ~pin_s[0] & sclk_prev_q;
  assign mosi_o      = pin_s[1];
  assign active_o    = ~pin_s[2];
endmodule

// File: rtl/spi_byte_rx.sv
`timescale 1ns/1ps
module spi_byte_rx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         active_i,
  input  logic         rise_i,
  input  logic         mosi_i,
  output logic         byte_done_o,
  output logic [W-1:0] byte_o,
  output logic         bit_zero_o
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] bit_q;
  logic [W-2:0]  sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q <= '0;
      sh_q  <= '0;
    end else if (!active_i) begin
      bit_q <= '0;
    end else if (rise_i) begin
      sh_q  <= {sh_q[W-3:0], mosi_i};
      bit_q <= (bit_q == LAST) ? '0 : bit_q + 1'b1;
    end
  end

  assign byte_done_o = rise_i & active_i & (bit_q == LAST);
  assign byte_o      = {sh_q, mosi_i};
  assign bit_zero_o  = (bit_q == '0);
endmodule

// File: rtl/spi_tx_shift.sv
`timescale 1ns/1ps
module spi_tx_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         active_i,
  input  logic         fall_i,
  input  logic         load_i,
  input  logic [W-1:0] load_data_i,
  output logic         miso_o
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst || !active_i)  sh_q <= '0;
    else if (fall_i)       sh_q <= load_i ? load_data_i : {sh_q[W-2:0], 1'b0};
  end

  assign miso_o = sh_q[W-1];
endmodule

// File: rtl/spi_cmd_ctrl.sv
`timescale 1ns/1ps
module spi_cmd_ctrl
  import spi_cmd_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int REG_W  = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active_i,
  input  logic              byte_done_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              fall_i,
  input  logic              bit_zero_i,
  output logic              load_o,
  output logic [BYTE_W-1:0] load_data_o,
  output logic              rxb_we_o,
  output logic [ADDR_W-1:0] rxb_addr_o,
  output logic [BYTE_W-1:0] rxb_wdata_o,
  output logic [ADDR_W-1:0] txb_addr_o,
  input  logic [BYTE_W-1:0] txb_rdata_i,
  output logic [IDX_W-1:0]  reg_idx_o,
  input  logic [REG_W-1:0]  reg_rdata_i,
  output logic              reg_we_o,
  output logic [REG_W-1:0]  reg_wdata_o
);
  localparam int REG_BYTES = REG_W / BYTE_W;
  localparam int CNT_W     = $clog2(REG_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(REG_BYTES);
  localparam logic [CNT_W-1:0] CNT_LST = CNT_W'(REG_BYTES - 1);

  mode_e                     mode_q;
  logic [ADDR_W-1:0]         wptr_q;
  logic [CNT_W-1:0]          cnt_q;
  logic [REG_W-BYTE_W-1:0]   acc_q;
  logic [REG_W-1:0]          hold_q;

  assign load_o = fall_i & bit_zero_i;

  always_comb begin
    load_data_o = '0;
    case (mode_q)
      MD_TXSTR: load_data_o = txb_rdata_i;
      MD_REGRD: begin
        if (cnt_q == '0)          load_data_o = reg_rdata_i[REG_W-1 -: BYTE_W];
        else if (cnt_q < CNT_END) load_data_o = hold_q[REG_W-1 -: BYTE_W];
      end
      default: load_data_o = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= MD_CMD;
      wptr_q      <= '0;
      cnt_q       <= '0;
      acc_q       <= '0;
      hold_q      <= '0;
      rxb_we_o    <= 1'b0;
      rxb_addr_o  <= '0;
      rxb_wdata_o <= '0;
      txb_addr_o  <= '0;
      reg_idx_o   <= '0;
      reg_we_o    <= 1'b0;
      reg_wdata_o <= '0;
    end else begin
      rxb_we_o <= 1'b0;
      reg_we_o <= 1'b0;
      if (!active_i) begin
        mode_q     <= MD_CMD;
        wptr_q     <= '0;
        txb_addr_o <= '0;
        cnt_q      <= '0;
      end else begin
        if (byte_done_i) begin
          case (mode_q)
            MD_CMD: begin
              mode_q    <= decode_op(byte_i);
              reg_idx_o <= byte_i[IDX_W-1:0];
            end
            MD_RXSTR: begin
              rxb_we_o    <= 1'b1;
              rxb_addr_o  <= wptr_q;
              rxb_wdata_o <= byte_i;
              wptr_q      <= wptr_q + 1'b1;
            end
            MD_REGWR: begin
              if (cnt_q < CNT_END) begin
                acc_q <= {acc_q[REG_W-2*BYTE_W-1:0], byte_i};
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == CNT_LST) begin
                  reg_we_o    <= 1'b1;
                  reg_wdata_o <= {acc_q, byte_i};
                end
              end
            end
            default: ;
          endcase
        end
        if (load_o) begin
          case (mode_q)
            MD_TXSTR: txb_addr_o <= txb_addr_o + 1'b1;
            MD_REGRD: begin
              if (cnt_q < CNT_END) begin
                cnt_q  <= cnt_q + 1'b1;
                hold_q <= (cnt_q == '0) ? (reg_rdata_i << BYTE_W) : (hold_q << BYTE_W);
              end
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/spi_cmd_slave.sv
`timescale 1ns/1ps
module spi_cmd_slave #(
  parameter int ADDR_W      = 12,
  parameter int REG_W       = 32,
  parameter int IDX_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sclk_i,
  input  logic              spi_mosi_i,
  input  logic              spi_ss_n_i,
  output logic              spi_miso_o,
  output logic              rxb_we_o,
  output logic [ADDR_W-1:0] rxb_addr_o,
  output logic [7:0]        rxb_wdata_o,
  output logic [ADDR_W-1:0] txb_addr_o,
  input  logic [7:0]        txb_rdata_i,
  output logic [IDX_W-1:0]  reg_idx_o,
  input  logic [REG_W-1:0]  reg_rdata_i,
  output logic              reg_we_o,
  output logic [REG_W-1:0]  reg_wdata_o
);
  localparam int BW = spi_cmd_pkg::BYTE_W;

  logic          rise, fall, mosi_s, active;
  logic          byte_done, bit_zero, load;
  logic [BW-1:0] byte_val, load_data;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sclk_i(spi_sclk_i), .mosi_i(spi_mosi_i), .ss_n_i(spi_ss_n_i),
    .sclk_rise_o(rise), .sclk_fall_o(fall), .mosi_o(mosi_s), .active_o(active)
  );

  spi_byte_rx #(.W(BW)) u_rx (
    .clk(clk), .rst(rst), .active_i(active), .rise_i(rise), .mosi_i(mosi_s),
    .byte_done_o(byte_done), .byte_o(byte_val), .bit_zero_o(bit_zero)
  );

  spi_cmd_ctrl #(.ADDR_W(ADDR_W), .REG_W(REG_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .active_i(active), .byte_done_i(byte_done), .byte_i(byte_val),
    .fall_i(fall), .bit_zero_i(bit_zero), .load_o(load), .load_data_o(load_data),
    .rxb_we_o(rxb_we_o), .rxb_addr_o(rxb_addr_o), .rxb_wdata_o(rxb_wdata_o),
    .txb_addr_o(txb_addr_o), .txb_rdata_i(txb_rdata_i),
    .reg_idx_o(reg_idx_o), .reg_rdata_i(reg_rdata_i),
    .reg_we_o(reg_we_o), .reg_wdata_o(reg_wdata_o)
  );

  spi_tx_shift #(.W(BW)) u_tx (
    .clk(clk), .rst(rst), .active_i(active), .fall_i(fall),
    .load_i(load), .load_data_i(load_data), .miso_o(spi_miso_o)
  );
endmodule

// File: rtl/spi_cmd_slave_chk.sv
`timescale 1ns/1ps
module spi_cmd_slave_chk #(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              spi_ss_n_i,
  input logic              spi_miso_o,
  input logic              rxb_we_o,
  input logic [ADDR_W-1:0] rxb_addr_o,
  input logic              reg_we_o,
  input logic [IDX_W-1:0]  reg_idx_o
);
  logic [3:0]        ss_hist_q;
  logic              seen_q;
  logic [ADDR_W-1:0] last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ss_hist_q <= '0;
      seen_q    <= 1'b0;
      last_q    <= '0;
    end else begin
      ss_hist_q <= {ss_hist_q[2:0], spi_ss_n_i};
      if (rxb_we_o) begin
        seen_q <= 1'b1;
        last_q <= rxb_addr_o;
      end else if (spi_ss_n_i) begin
        seen_q <= 1'b0;
      end
    end
  end

  p_rxwe_single_r3: assert property (@(posedge clk) disable iff (rst)
    rxb_we_o |=> !rxb_we_o);
  p_regwe_single_r6: assert property (@(posedge clk) disable iff (rst)
    reg_we_o |=> !reg_we_o);
  p_regwe_idx_held_r6: assert property (@(posedge clk) disable iff (rst)
    reg_we_o |-> $stable(reg_idx_o));
  p_modes_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(rxb_we_o && reg_we_o));
  p_rx_addr_step_r8: assert property (@(posedge clk) disable iff (rst)
    (rxb_we_o && seen_q) |-> (rxb_addr_o == last_q + 1'b1));
  p_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    ((&ss_hist_q) && spi_ss_n_i) |-> (!rxb_we_o && !reg_we_o && !spi_miso_o));
endmodule

bind spi_cmd_slave spi_cmd_slave_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .spi_ss_n_i(spi_ss_n_i), .spi_miso_o(spi_miso_o),
  .rxb_we_o(rxb_we_o), .rxb_addr_o(rxb_addr_o), .reg_we_o(reg_we_o), .reg_idx_o(reg_idx_o)
);

// File: tb/spi_cmd_slave_tb_top.sv
`timescale 1ns/1ps
module spi_cmd_slave_tb_top;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst, sclk, mosi, ss_n, miso;
  logic rxb_we, reg_we;
  logic [AW-1:0] rxb_addr, txb_addr;
  logic [7:0] rxb_wdata, txb_rdata;
  logic [3:0] reg_idx;
  logic [31:0] reg_rdata, reg_wdata;

  logic [7:0]  txmem [DEPTH];
  logic [31:0] regs  [16];

  int checks = 0, errs = 0, ss_hi_cnt = 0;
  bit done = 0;
  realtime last_rise = 0.0;
  logic [7:0] mq[$], gq[$], eq[$];
  int ex_rx_a[$], ex_rx_d[$], ex_rg_i[$];
  logic [31:0] ex_rg_d[$];

  always #2.5 clk = ~clk;

  spi_cmd_slave #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .spi_sclk_i(sclk), .spi_mosi_i(mosi), .spi_ss_n_i(ss_n),
    .spi_miso_o(miso), .rxb_we_o(rxb_we), .rxb_addr_o(rxb_addr), .rxb_wdata_o(rxb_wdata),
    .txb_addr_o(txb_addr), .txb_rdata_i(txb_rdata), .reg_idx_o(reg_idx),
    .reg_rdata_i(reg_rdata), .reg_we_o(reg_we), .reg_wdata_o(reg_wdata)
  );

  always @(posedge clk) begin
    txb_rdata <= txmem[txb_addr];
    reg_rdata <= regs[reg_idx];
  end

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // Reference model: every clock, strobes are compared against the expected-write queues.
  always @(negedge clk) begin
    if (!rst) begin
      if (rxb_we) begin
        if (ex_rx_a.size() == 0) chk(0, "R3 unexpected buffer write", {rxb_addr, rxb_wdata}, 0);
        else begin
          chk(rxb_addr == AW'(ex_rx_a[0]) && rxb_wdata == 8'(ex_rx_d[0]), "R3 buffer write addr/data",
              {rxb_addr, rxb_wdata}, {AW'(ex_rx_a[0]), 8'(ex_rx_d[0])});
          void'(ex_rx_a.pop_front()); void'(ex_rx_d.pop_front());
        end
        chk(($realtime - last_rise) <= 20.0, "R3 write latency ns", longint'($realtime - last_rise), 20);
      end
      if (reg_we) begin
        if (ex_rg_i.size() == 0) chk(0, "R6 unexpected register write", reg_wdata, 0);
        else begin
          chk(reg_idx == 4'(ex_rg_i[0]) && reg_wdata == ex_rg_d[0], "R6 register write idx/data",
              {reg_idx, reg_wdata}, {4'(ex_rg_i[0]), ex_rg_d[0]});
          void'(ex_rg_i.pop_front()); void'(ex_rg_d.pop_front());
        end
        chk(($realtime - last_rise) <= 20.0, "R6 write latency ns", longint'($realtime - last_rise), 20);
        regs[reg_idx] = reg_wdata;
      end
      ss_hi_cnt = ss_n ? ss_hi_cnt + 1 : 0;
      if (ss_hi_cnt >= 4 && miso !== 1'b0) chk(0, "R9 MISO idle low", miso, 0);
    end
  end

  task automatic spi_xfer(input int half);
    gq.delete();
    ss_n = 1'b0;
    #(half);
    foreach (mq[i]) begin
      logic [7:0] got;
      for (int k = 7; k >= 0; k--) begin
        mosi = mq[i][k];
        #(half);
        sclk = 1'b1;
        last_rise = $realtime;
        got[k] = miso;
        #(half);
        sclk = 1'b0;
      end
      gq.push_back(got);
    end
    #(half);
    ss_n = 1'b1;
    mosi = 1'b0;
    #(8 * half);
  endtask

  task automatic spi_partial(input int half, input int nbits);
    ss_n = 1'b0;
    #(half);
    for (int k = 0; k < nbits; k++) begin
      mosi = 1'b0;
      #(half); sclk = 1'b1; #(half); sclk = 1'b0;
    end
    #(half);
    ss_n = 1'b1;
    #(8 * half);
  endtask

  task automatic run(input int half, input string req);
    spi_xfer(half);
    chk(ex_rx_a.size() == 0 && ex_rg_i.size() == 0, {req, " all expected writes seen"},
        ex_rx_a.size() + ex_rg_i.size(), 0);
    chk(gq.size() == eq.size(), {req, " MISO byte count"}, gq.size(), eq.size());
    foreach (eq[i]) if (i < gq.size())
      chk(gq[i] == eq[i], $sformatf("%s MISO byte %0d", req, i), gq[i], eq[i]);
    ex_rx_a.delete(); ex_rx_d.delete(); ex_rg_i.delete(); ex_rg_d.delete();
  endtask

  task automatic zeros(input int n);
    eq.delete();
    for (int i = 0; i < n; i++) eq.push_back(8'h00);
  endtask

  initial begin
    #800us;
    if (!done) begin
      chk(0, "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; ss_n = 1'b1; sclk = 1'b0; mosi = 1'b0;
    for (int i = 0; i < DEPTH; i++) txmem[i] = 8'h3C ^ 8'(i * 23);
    for (int i = 0; i < 16; i++) regs[i] = 32'hA500_0000 ^ (i * 32'h0102_0304);
    repeat (5) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(miso == 0 && rxb_we == 0 && reg_we == 0, "R10 outputs low after reset", {miso, rxb_we, reg_we}, 0);
    #1;

    // R1 / R3: receive stream, MSB-first byte assembly
    mq = '{8'h03, 8'h80, 8'h01, 8'h5A, 8'hC3, 8'h7E};
    for (int i = 1; i < 6; i++) begin ex_rx_a.push_back(i - 1); ex_rx_d.push_back(mq[i]); end
    zeros(6); run(20, "R1 R3 rx stream");

    // R6: register write, fifth byte ignored
    mq = '{8'hC5, 8'hDE, 8'hAD, 8'hBE, 8'hEF, 8'h77};
    ex_rg_i.push_back(5); ex_rg_d.push_back(32'hDEADBEEF);
    zeros(6); run(20, "R6 reg write");

    // R5: read back, MSB byte first, extra byte zero
    mq = '{8'h85, 8'hFF, 8'h00, 8'hFF, 8'h00, 8'hFF};
    eq = '{8'h00, 8'hDE, 8'hAD, 8'hBE, 8'hEF, 8'h00};
    run(20, "R5 R1 reg read");

    // R5: read of an untouched register
    begin
      logic [31:0] v = 32'hA500_0000 ^ (10 * 32'h0102_0304);
      mq = '{8'h8A, 8'h00, 8'h00, 8'h00, 8'h00};
      eq = '{8'h00, v[31:24], v[23:16], v[15:8], v[7:0]};
      run(20, "R5 reg read idx 10");
    end

    // R4: transmit stream, incoming data ignored
    mq = '{8'h01, 8'h03, 8'hC2, 8'hFF, 8'h00};
    eq = '{8'h00, txmem[0], txmem[1], txmem[2], txmem[3]};
    run(20, "R4 tx stream");

    // R2: unknown command ignores the rest
    mq = '{8'h55, 8'h03, 8'hC1, 8'h11, 8'h22, 8'h33, 8'h44};
    zeros(7); run(20, "R2 unknown command");

    // R7: partial byte discarded, fresh command afterwards
    spi_partial(20, 5);
    mq = '{8'h03, 8'hA1, 8'hB2};
    ex_rx_a = '{0, 1}; ex_rx_d = '{8'hA1, 8'hB2};
    zeros(3); run(20, "R7 after partial byte");

    // R7: incomplete register write dropped, then a new stream starts at 0
    mq = '{8'hC7, 8'h12, 8'h34};
    zeros(3); run(20, "R7 incomplete reg write");
    mq = '{8'h03, 8'h44};
    ex_rx_a = '{0}; ex_rx_d = '{8'h44};
    zeros(2); run(20, "R7 stream restarts at 0");

    // R8: receive wrap
    mq = '{8'h03};
    for (int i = 0; i < DEPTH + 2; i++) begin
      mq.push_back(8'(i * 7 + 1)); ex_rx_a.push_back(i % DEPTH); ex_rx_d.push_back(8'(i * 7 + 1));
    end
    zeros(DEPTH + 3); run(20, "R8 rx wrap");

    // R8: transmit wrap
    mq = '{8'h01}; eq = '{8'h00};
    for (int i = 0; i < DEPTH + 2; i++) begin mq.push_back(8'hA5); eq.push_back(txmem[i % DEPTH]); end
    run(20, "R8 tx wrap");

    // R9: receive side at SCLK = clk/4
    mq = '{8'h03, 8'h0F, 8'hF0, 8'h96, 8'h69};
    ex_rx_a = '{0, 1, 2, 3}; ex_rx_d = '{8'h0F, 8'hF0, 8'h96, 8'h69};
    zeros(5); run(10, "R9 fast rx stream");
    mq = '{8'hC3, 8'h01, 8'h23, 8'h45, 8'h67};
    ex_rg_i.push_back(3); ex_rg_d.push_back(32'h01234567);
    zeros(5); run(10, "R9 fast reg write");
    mq = '{8'h83, 8'h00, 8'h00, 8'h00, 8'h00};
    eq = '{8'h00, 8'h01, 8'h23, 8'h45, 8'h67};
    run(20, "R9 read back of fast write");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule